// File: doc/BRIEF.md
# Periodic Interrupt Timer with Change Flag

This block supports a real-time clock. A prescaler divides the system clock into a 1 ms tick. Every 100 ms a one-cycle update pulse is issued to advance the time-of-day registers, which are outside this block. Each update pulse sets a change flag that the host polls. Reading the status register returns the flag and clears it. A host that finds the flag set therefore knows that the time registers have just moved.

An interrupt timer counts whole milliseconds from a selectable period. It runs in one of two modes. In one-shot mode it raises a single interrupt and then goes idle. In repeating mode it reloads on the expiry tick itself, so every interrupt after the first keeps an exact spacing, however late the host acknowledges. The host can align the timer to the update pulses: it polls the flag until it is set, then writes the start command at once. From then on, every interrupt arrives one cycle after an update pulse. A halt command freezes the timer and its remaining count.

The timer is a four-state machine. IDLE waits for a start. ONE_SHOT counts down and returns to IDLE on expiry (transition "expire-once"). REPEATING counts down and reloads on expiry (transition "expire-reload"). HALTED holds the count. Any control write overrides the current state: a start with repeat=0 goes to ONE_SHOT, a start with repeat=1 goes to REPEATING, and halt=1 goes to HALTED.

Top module: `rtc_tick_timer`

## Requirements
- R1: `upd_pulse` is high for exactly one cycle every 100·CLK_PER_MS cycles, and always in a cycle that holds a millisecond tick.
- R2: An update pulse sets the change flag, which is status bit 0 at address 0. If a status read falls in the same cycle as an update pulse, the flag stays set.
- R3: A read at address 0 returns the flag and clears it from the next cycle. A read at address 1 returns the remaining count in milliseconds and clears nothing.
- R4: A write at address 0 uses these fields: bit 0 = halt, bit 1 = repeat, bits 4:2 = period code. The period codes are 0→100, 1→500, 2→1000, 3→5000, 4→10000, 5→30000, 6→60000 and 7→100 ms. A write with halt=0 loads the period and starts the timer.
- R5: In one-shot mode, `irq` rises between W+2+(P−1)·CLK_PER_MS and W+1+P·CLK_PER_MS, where W is the write cycle. The timer then goes idle with a count of 0 and raises no further interrupt.
- R6: In repeating mode, each interrupt after the first rises exactly P·CLK_PER_MS cycles after the previous one, whenever it was acknowledged.
- R7: `irq` rises the cycle after an expiry. It stays high, and status bit 1 reads 1, until a read at address 0 clears it.
- R8: If a repeating start is written two cycles after an update pulse (one cycle after a read that saw the flag), every interrupt rises exactly one cycle after an update pulse.
- R9: While halted (status bits 3:2 = 3), no interrupt is raised and the count read at address 1 does not change.
- R10: After reset the status reads 0 (idle = 0, one-shot = 1, repeating = 2 in bits 3:2), `irq` is low and the count is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = control/status, 1 = remaining count |
| wdata | input | 5 | Control word |
| rdata | output | 16 | Read data, valid in the cycle `rd_en` is high |
| upd_pulse | output | 1 | 100 ms time-register update pulse |
| irq | output | 1 | Interrupt request to the host |

## Verification
A read that lands in the same cycle as an update pulse is the hardest case for the flag: a design that gives priority to the clear would lose that change, and the next poll would read 0. The aligned start is checked cycle by cycle. If the write were allowed to consume a pending tick, or the expiry were decoded one count late, the interrupts would drift one millisecond away from the update pulses. Repeating mode is acknowledged after short, medium and nearly full-period delays. A design that reloaded on the acknowledge would let the spacing grow. The halt case reads the count twice, far apart: a timer that kept counting, or fired while halted, shows up there.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        TMR_IDLE   = 2'd0,
        TMR_ONCE   = 2'd1,
        TMR_REPEAT = 2'd2,
        TMR_HALT   = 2'd3
    } tmr_state_e;

    typedef struct packed {
        logic [2:0] period_sel;
        logic       repeat_en;
        logic       halt;
    } ctrl_word_t;

    function automatic logic [CNT_W-1:0] period_ms(input logic [2:0] sel);
        logic [CNT_W-1:0] p;
        unique case (sel)
            3'd0:    p = 16'd100;
            3'd1:    p = 16'd500;
            3'd2:    p = 16'd1000;
            3'd3:    p = 16'd5000;
            3'd4:    p = 16'd10000;
            3'd5:    p = 16'd30000;
            3'd6:    p = 16'd60000;
            default: p = 16'd100;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int CLK_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ms_tick
);
    generate
        if (CLK_PER_MS <= 1) begin : g_passthru
            assign ms_tick = rst_n;
        end else begin : g_divide
            localparam int CW = $clog2(CLK_PER_MS);
            localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);
            logic [CW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign ms_tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rtc_update_gen.sv
module rtc_update_gen #(
    parameter int MS_PER_UPDATE = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    output logic upd_pulse
);
    localparam int UW = (MS_PER_UPDATE > 1) ? $clog2(MS_PER_UPDATE) : 1;
    localparam logic [UW-1:0] ULAST = UW'(MS_PER_UPDATE - 1);

    logic [UW-1:0] ms_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_q <= '0;
        end else if (ms_tick) begin
            ms_q <= (ms_q == ULAST) ? '0 : ms_q + 1'b1;
        end
    end

    assign upd_pulse = ms_tick && (ms_q == ULAST);
endmodule

// File: rtl/rtc_timeout_fsm.sv
module rtc_timeout_fsm
    import rtc_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             ctrl_wr,
    input  ctrl_word_t       ctrl_w,
    output logic             tmo,
    output logic [CNT_W-1:0] count,
    output tmr_state_e       state
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [2:0]       sel_q;
    logic             running;
    logic             expire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (ctrl_w.halt) begin
                state_d = TMR_HALT;
            end else if (ctrl_w.repeat_en) begin
                state_d = TMR_REPEAT;
            end else begin
                state_d = TMR_ONCE;
            end
        end else begin
            unique case (state_q)
                TMR_IDLE:   state_d = TMR_IDLE;
                TMR_ONCE:   state_d = expire ? TMR_IDLE : TMR_ONCE;
                TMR_REPEAT: state_d = TMR_REPEAT;
                TMR_HALT:   state_d = TMR_HALT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        running = (state_q == TMR_ONCE) || (state_q == TMR_REPEAT);
        expire  = running && ms_tick && !ctrl_wr && (count_q == CNT_W'(1));
        tmo     = expire;
        count   = count_q;
        state   = state_q;
    end

    // Millisecond down-counter; a start write wins over a same-cycle tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            sel_q   <= '0;
        end else if (ctrl_wr && !ctrl_w.halt) begin
            count_q <= period_ms(ctrl_w.period_sel);
            sel_q   <= ctrl_w.period_sel;
        end else if (running && ms_tick && !ctrl_wr) begin
            if (count_q == CNT_W'(1)) begin
                count_q <= (state_q == TMR_REPEAT) ? period_ms(sel_q) : '0;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_host_regs.sv
module rtc_host_regs
    import rtc_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             addr,
    input  logic             upd_pulse,
    input  logic             tmo,
    input  logic [CNT_W-1:0] count,
    input  tmr_state_e       state,
    output logic             chg_flag,
    output logic             irq,
    output logic [15:0]      rdata
);
    logic stat_rd;

    assign stat_rd = rd_en && !addr;

    // Setting has priority so no event is lost to a coincident read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (upd_pulse) begin
                chg_flag <= 1'b1;
            end else if (stat_rd) begin
                chg_flag <= 1'b0;
            end
            if (tmo) begin
                irq <= 1'b1;
            end else if (stat_rd) begin
                irq <= 1'b0;
            end
        end
    end

    always_comb begin
        if (addr) begin
            rdata = 16'(count);
        end else begin
            rdata = {12'd0, state, irq, chg_flag};
        end
    end
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
    import rtc_tick_pkg::*;
#(
    parameter int CLK_PER_MS    = 50000,
    parameter int MS_PER_UPDATE = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic        addr,
    input  logic [4:0]  wdata,
    output logic [15:0] rdata,
    output logic        upd_pulse,
    output logic        irq
);
    logic             ms_tick;
    logic             tmo;
    logic             ctrl_wr;
    logic             chg_flag;
    ctrl_word_t       ctrl_w;
    logic [CNT_W-1:0] tmr_count;
    tmr_state_e       tmr_state;

    assign ctrl_wr = wr_en && !addr;
    assign ctrl_w  = ctrl_word_t'(wdata);

    rtc_prescale #(.CLK_PER_MS(CLK_PER_MS)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick)
    );

    rtc_update_gen #(.MS_PER_UPDATE(MS_PER_UPDATE)) u_update (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_tick   (ms_tick),
        .upd_pulse (upd_pulse)
    );

    rtc_timeout_fsm u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .ctrl_wr (ctrl_wr),
        .ctrl_w  (ctrl_w),
        .tmo     (tmo),
        .count   (tmr_count),
        .state   (tmr_state)
    );

    rtc_host_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .addr      (addr),
        .upd_pulse (upd_pulse),
        .tmo       (tmo),
        .count     (tmr_count),
        .state     (tmr_state),
        .chg_flag  (chg_flag),
        .irq       (irq),
        .rdata     (rdata)
    );
endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk
    import rtc_tick_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             addr,
    input logic             upd_pulse,
    input logic             ms_tick,
    input logic             irq,
    input logic             tmo,
    input logic             chg_flag,
    input logic [CNT_W-1:0] tmr_count,
    input tmr_state_e       tmr_state
);
    assert_upd_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> ms_tick);

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> chg_flag);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && !upd_pulse) |=> !chg_flag);

    assert_once_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_state == TMR_ONCE && tmo && !wr_en) |=> (tmr_state == TMR_IDLE));

    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tmo));

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && !addr)) |=> irq);

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_state == TMR_HALT) |-> !tmo);

    assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_state == TMR_HALT && !wr_en) |=> $stable(tmr_count));
endmodule

bind rtc_tick_timer rtc_tick_timer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .upd_pulse (upd_pulse),
    .ms_tick   (ms_tick),
    .irq       (irq),
    .tmo       (tmo),
    .chg_flag  (chg_flag),
    .tmr_count (tmr_count),
    .tmr_state (tmr_state)
);

// File: tb/test_rtc_tick_timer.sv
`timescale 1ns/1ps
module test_rtc_tick_timer;
    localparam int C   = 8;
    localparam int UPD = 100 * C;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        addr = 1'b0;
    logic [4:0]  wdata = '0;
    logic [15:0] rdata;
    logic        upd_pulse;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_upd = -1;
    int rise_cyc = -1;
    int rise_cnt = 0;
    logic irq_prev = 1'b0;
    int exp_q[$];
    string cur_req = "R6";

    rtc_tick_timer #(.CLK_PER_MS(C), .MS_PER_UPDATE(100)) i_rtc_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .upd_pulse(upd_pulse), .irq(irq)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_LIMIT) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp<%0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: update spacing and interrupt scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_pulse) begin
                if (last_upd >= 0)
                    chk(cyc - last_upd == UPD, "R1", "update spacing", cyc - last_upd, UPD);
                last_upd = cyc;
            end
            if (irq && !irq_prev) begin
                rise_cyc = cyc;
                rise_cnt = rise_cnt + 1;
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    chk(cyc == e, cur_req, "interrupt cycle", cyc, e);
                end
            end
            irq_prev = irq;
        end
    end

    // Bus tasks: called at a negedge, return at the next negedge
    task automatic bus_read(input logic a, output logic [15:0] d);
        rd_en = 1'b1;
        addr  = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        addr  = 1'b0;
    endtask

    task automatic bus_write(input logic [4:0] w);
        wr_en = 1'b1;
        addr  = 1'b0;
        wdata = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise(input int prev);
        while (rise_cnt == prev) @(negedge clk);
    endtask

    task automatic wait_upd();
        int p;
        p = last_upd;
        while (last_upd == p) @(negedge clk);
    endtask

    // Control word: [4:2] period code, [1] repeat, [0] halt
    function automatic logic [4:0] cw(input int code, input bit rep, input bit halt);
        return {3'(code), rep, halt};
    endfunction

    task automatic sync_start(input logic [4:0] w);
        logic [15:0] d;
        bus_read(1'b0, d);
        do bus_read(1'b0, d); while (!d[0]);
        bus_write(w);
    endtask

    initial begin
        logic [15:0] d;
        logic [15:0] c1;
        int w, prev, lo, hi, base, tgt;

        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        bus_read(1'b0, d);
        chk(d == 16'd0, "R10", "status after reset", d, 0);
        chk(irq == 1'b0, "R10", "irq after reset", irq, 0);
        bus_read(1'b1, d);
        chk(d == 16'd0, "R10", "count after reset", d, 0);

        // R2/R3 flag set and cleared by status read
        wait_upd();
        bus_read(1'b0, d);
        chk(d[0] == 1'b1, "R2", "flag after update", d[0], 1);
        bus_read(1'b0, d);
        chk(d[0] == 1'b0, "R3", "flag after status read", d[0], 0);
        wait_upd();
        bus_read(1'b1, d);
        bus_read(1'b0, d);
        chk(d[0] == 1'b1, "R3", "count read keeps flag", d[0], 1);

        // R2 read coinciding with update: set wins
        tgt = last_upd + UPD;
        while (cyc != tgt) @(negedge clk);
        chk(upd_pulse == 1'b1, "R1", "pulse at predicted cycle", upd_pulse, 1);
        bus_read(1'b0, d);
        bus_read(1'b0, d);
        chk(d[0] == 1'b1, "R2", "flag kept on coincident read", d[0], 1);

        // R5 one-shot 100 ms
        w = cyc;
        prev = rise_cnt;
        bus_write(cw(0, 1'b0, 1'b0));
        wait_rise(prev);
        lo = w + 2 + 99 * C;
        hi = w + 1 + 100 * C;
        chk(rise_cyc >= lo && rise_cyc <= hi, "R5", "one-shot rise", rise_cyc, lo);
        wait_cycles(50);
        chk(irq == 1'b1, "R7", "irq held until ack", irq, 1);
        bus_read(1'b0, d);
        chk(d[1] == 1'b1, "R7", "status irq bit", d[1], 1);
        chk(irq == 1'b0, "R7", "irq after ack", irq, 0);
        chk(d[3:2] == 2'd0, "R5", "state idle after expiry", d[3:2], 0);
        prev = rise_cnt;
        wait_cycles(100 * C + 50);
        chk(rise_cnt == prev, "R5", "no second one-shot irq", rise_cnt, prev);
        bus_read(1'b1, d);
        chk(d == 16'd0, "R5", "count zero after one-shot", d, 0);

        // R8/R6 aligned repeating 100 ms, acks at varied delays
        cur_req = "R8";
        sync_start(cw(0, 1'b1, 1'b0));
        base = last_upd;
        for (int k = 1; k <= 4; k++) exp_q.push_back(base + k * UPD + 1);
        for (int k = 0; k < 4; k++) begin
            prev = rise_cnt;
            wait_rise(prev);
            chk(rise_cyc == last_upd + 1, "R8", "irq one cycle after update", rise_cyc, last_upd + 1);
            wait_cycles(k == 1 ? 700 : (k == 2 ? 5 : 100));
            bus_read(1'b0, d);
        end
        chk(exp_q.size() == 0, "R6", "all repeats seen", exp_q.size(), 0);

        // R9 halt holds count and stops interrupts
        wait_cycles(200);
        bus_write(cw(0, 1'b0, 1'b1));
        bus_read(1'b0, d);
        chk(d[3:2] == 2'd3, "R9", "halted state code", d[3:2], 3);
        bus_read(1'b1, c1);
        prev = rise_cnt;
        wait_cycles(2000);
        bus_read(1'b1, d);
        chk(d == c1, "R9", "count frozen while halted", d, c1);
        chk(rise_cnt == prev, "R9", "no irq while halted", rise_cnt, prev);

        // R4/R6 unaligned repeating 500 ms
        cur_req = "R6";
        w = cyc;
        prev = rise_cnt;
        bus_write(cw(1, 1'b1, 1'b0));
        bus_read(1'b0, d);
        chk(d[3:2] == 2'd2, "R4", "repeating state code", d[3:2], 2);
        wait_rise(prev);
        lo = w + 2 + 499 * C;
        hi = w + 1 + 500 * C;
        chk(rise_cyc >= lo && rise_cyc <= hi, "R4", "500 ms first expiry", rise_cyc, lo);
        base = rise_cyc;
        exp_q.push_back(base + 500 * C);
        exp_q.push_back(base + 1000 * C);
        wait_cycles(3000);
        bus_read(1'b0, d);
        prev = rise_cnt;
        wait_rise(prev);
        wait_cycles(30);
        bus_read(1'b0, d);
        prev = rise_cnt;
        wait_rise(prev);
        bus_read(1'b0, d);
        chk(exp_q.size() == 0, "R6", "500 ms repeats seen", exp_q.size(), 0);
        bus_write(cw(0, 1'b0, 1'b1));

        // R4 one-shot 1000 ms
        w = cyc;
        prev = rise_cnt;
        bus_write(cw(2, 1'b0, 1'b0));
        bus_read(1'b1, d);
        chk(d == 16'd1000, "R4", "loaded 1000 ms count", d, 1000);
        wait_rise(prev);
        lo = w + 2 + 999 * C;
        hi = w + 1 + 1000 * C;
        chk(rise_cyc >= lo && rise_cyc <= hi, "R4", "1000 ms expiry", rise_cyc, lo);
        bus_read(1'b0, d);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule